// File: doc/BRIEF.md
# Two-Wire Serial Programming Sequencer

This block is the host-side master for putting a flash target into program/verify mode and talking to it over two wires: a serial clock it always drives and a data line it drives or releases. It runs four kinds of job. A write job shifts a 4-bit command followed by a 16-bit operand. A read job shifts the command and then turns the data line around to collect a 16-bit word from the target. A program or erase job is a write job followed by a long idle period while the target works. An entry job asserts the target reset line, waits, shifts a 32-bit key, and then releases reset.

Every timing figure, including the clock high and low phases, the gaps between fields and the millisecond-scale waits, is a parameter counted in system-clock cycles. Jobs arrive on a valid/ready request channel. A request is taken in the cycle where `req_valid` and `req_ready` are both high, and its fields are sampled only in that cycle. `req_ready` is high only while the block is idle. Read results leave on a valid/ready response channel. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is seen, and no new request is taken while a response is waiting.

Top module: `twsp_sequencer`

## Requirements
- R1: After reset, `ser_clk` is 0, `ser_dat_oe` is 1, `tgt_reset` is 0, `busy` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted only while `req_ready` is high. `busy` rises in the cycle after acceptance and stays high, with `req_ready` low, until the job ends. `req_op` encodings are: 0 write, 1 read, 2 program, 3 row erase, 4 bulk erase, 5 entry. Codes 6 and 7 act as write.
- R3: Every job except entry first gives 4 clock pulses that carry `req_cmd`, least significant bit first. Non-read jobs then give 16 more pulses that carry `req_data`, least significant bit first. The value of a bit is `ser_dat_o` while `ser_clk` is high.
- R4: Every high phase of `ser_clk` lasts exactly T_HI cycles. Inside a field, the low phase before each rising edge lasts exactly T_LO cycles. `ser_dat_o` never changes while the clock is high.
- R5: The low time before the first operand pulse is G_CMD + T_LO cycles.
- R6: For a read job, `ser_dat_oe` is 0 from the start of a G_RD-cycle gap after the command gap through all 16 read pulses. The low time before the first read pulse is G_CMD + G_RD + T_LO. The bit on `ser_dat_i` at the end of each low phase is collected least significant first and presented on `rsp_data` with `rsp_valid`. Both hold until `rsp_ready`, and `busy` stays high until the response is taken.
- R7: After the last pulse of a job other than entry, the clock stays low for G_END cycles before any wait, response or return to idle.
- R8: Program, row-erase and bulk-erase jobs keep `busy` high for a further W_PROG, W_ROW or W_BULK cycles after the end gap.
- R9: An entry job raises `tgt_reset`, waits KEY_LEAD + T_LO cycles to the first rising clock, and shifts the 32-bit KEY_VALUE least significant bit first. It then keeps the clock low for KEY_TAIL cycles and releases `tgt_reset` as `busy` falls. The `req_cmd` and `req_data` fields are ignored.
- R10: `tgt_reset` changes only when `ser_clk` was low in both the previous and the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, high only while idle |
| req_op | input | 3 | Job kind |
| req_cmd | input | CMD_W | Command nibble |
| req_data | input | DATA_W | Operand word |
| rsp_valid | output | 1 | Read word valid |
| rsp_ready | input | 1 | Read word taken |
| rsp_data | output | DATA_W | Read word |
| busy | output | 1 | Job in progress |
| ser_clk | output | 1 | Serial clock to target |
| ser_dat_o | output | 1 | Serial data out |
| ser_dat_oe | output | 1 | Data line drive enable |
| ser_dat_i | input | 1 | Serial data in |
| tgt_reset | output | 1 | Target reset line, active high |

## Verification
The bench goes after the field boundaries. It measures the low time before the first operand pulse and before the first read pulse, where a missing or merged gap shows up as a shortened count. It holds `rsp_ready` low for several cycles to catch a design that drops or changes the read word under back-pressure, or that reopens `req_ready` early. It checks the entry key order and the reset lead and tail times, where swapped bit order or a reset released with the clock would stand out. It also checks the per-job busy length, where a wrong wait selection shows up as a busy count off by tens of cycles.

// File: rtl/twsp_pkg.sv
package twsp_pkg;
  typedef enum logic [2:0] {
    OP_WRITE     = 3'd0,
    OP_READ      = 3'd1,
    OP_PROG      = 3'd2,
    OP_ROWERASE  = 3'd3,
    OP_BULKERASE = 3'd4,
    OP_ENTER     = 3'd5
  } twsp_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LEAD, S_LO, S_HI, S_GAP_CMD, S_GAP_RD,
    S_GAP_END, S_WAIT, S_RSP, S_TAIL
  } twsp_state_e;

  typedef enum logic [1:0] {
    F_CMD, F_DATA, F_READ, F_KEY
  } twsp_field_e;
endpackage

// File: rtl/twsp_timer.sv
module twsp_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/twsp_shreg.sv
module twsp_shreg #(
  parameter int SH_W   = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SH_W-1:0]   load_val,
  input  logic              shift,
  input  logic              in_bit,
  output logic              lsb,
  output logic [WORD_W-1:0] top_word
);
  logic [SH_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {in_bit, q[SH_W-1:1]};
  end

  assign lsb      = q[0];
  assign top_word = q[SH_W-1 -: WORD_W];
endmodule

// File: rtl/twsp_sequencer.sv
module twsp_sequencer
  import twsp_pkg::*;
#(
  parameter int             CMD_W     = 4,
  parameter int             DATA_W    = 16,
  parameter int             KEY_W     = 32,
  parameter logic [KEY_W-1:0] KEY_VALUE = 32'hA5C3_0F96,
  parameter int             CNT_W     = 32,
  parameter int             T_LO      = 5,
  parameter int             T_HI      = 5,
  parameter int             G_CMD     = 5,
  parameter int             G_RD      = 2,
  parameter int             G_END     = 5,
  parameter int             W_PROG    = 120000,
  parameter int             W_ROW     = 4900000,
  parameter int             W_BULK    = 47500000,
  parameter int             KEY_LEAD  = 400000,
  parameter int             KEY_TAIL  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              ser_clk,
  output logic              ser_dat_o,
  output logic              ser_dat_oe,
  input  logic              ser_dat_i,
  output logic              tgt_reset
);
  localparam int PAIR_W = CMD_W + DATA_W;
  localparam int SH_W   = (KEY_W > PAIR_W) ? KEY_W : PAIR_W;
  localparam int BC_W   = $clog2(SH_W + 1);

  twsp_state_e      st_q, st_n;
  twsp_field_e      fld_q, fld_n;
  logic [2:0]       op_q, op_n;
  logic [BC_W-1:0]  bc_q, bc_n;
  logic             clk_q, clk_n, oe_q, oe_n, tr_q, tr_n;

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_in, sh_lsb;
  logic [SH_W-1:0]  sh_val;
  logic [DATA_W-1:0] sh_word;

  function automatic logic [CNT_W-1:0] span(input int n);
    return (n > 0) ? CNT_W'(n - 1) : '0;
  endfunction

  function automatic logic [BC_W-1:0] last_bit(input twsp_field_e f);
    case (f)
      F_CMD:   return BC_W'(CMD_W - 1);
      F_KEY:   return BC_W'(KEY_W - 1);
      default: return BC_W'(DATA_W - 1);
    endcase
  endfunction

  twsp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  twsp_shreg #(.SH_W(SH_W), .WORD_W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .in_bit(sh_in), .lsb(sh_lsb), .top_word(sh_word)
  );

  always_comb begin
    st_n = st_q;  fld_n = fld_q; op_n = op_q; bc_n = bc_q;
    clk_n = clk_q; oe_n = oe_q; tr_n = tr_q;
    tmr_load = 1'b0; tmr_val = '0;
    sh_load = 1'b0;  sh_val = '0; sh_shift = 1'b0; sh_in = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        op_n     = req_op;
        tmr_load = 1'b1;
        if (req_op == OP_ENTER) begin
          st_n = S_LEAD; tr_n = 1'b1; tmr_val = span(KEY_LEAD);
        end else begin
          st_n = S_LO; fld_n = F_CMD; bc_n = '0; tmr_val = span(T_LO);
          sh_load = 1'b1; sh_val = SH_W'({req_data, req_cmd});
        end
      end
      S_LEAD: if (tmr_zero) begin
        st_n = S_LO; fld_n = F_KEY; bc_n = '0;
        sh_load = 1'b1; sh_val = SH_W'(KEY_VALUE);
        tmr_load = 1'b1; tmr_val = span(T_LO);
      end
      S_LO: if (tmr_zero) begin
        st_n = S_HI; clk_n = 1'b1;
        tmr_load = 1'b1; tmr_val = span(T_HI);
        if (fld_q == F_READ) begin
          sh_shift = 1'b1; sh_in = ser_dat_i;   // R6: sample at end of low phase
        end
      end
      S_HI: if (tmr_zero) begin
        clk_n = 1'b0; tmr_load = 1'b1;
        sh_shift = (fld_q != F_READ);
        bc_n = bc_q + 1'b1;
        if (bc_q == last_bit(fld_q)) begin
          case (fld_q)
            F_CMD:   begin st_n = S_GAP_CMD; tmr_val = span(G_CMD); end
            F_KEY:   begin st_n = S_TAIL;    tmr_val = span(KEY_TAIL); end
            default: begin st_n = S_GAP_END; tmr_val = span(G_END); oe_n = 1'b1; end
          endcase
        end else begin
          st_n = S_LO; tmr_val = span(T_LO);
        end
      end
      S_GAP_CMD: if (tmr_zero) begin
        tmr_load = 1'b1; bc_n = '0;
        if (op_q == OP_READ) begin
          st_n = S_GAP_RD; oe_n = 1'b0; tmr_val = span(G_RD);
        end else begin
          st_n = S_LO; fld_n = F_DATA; tmr_val = span(T_LO);
        end
      end
      S_GAP_RD: if (tmr_zero) begin
        st_n = S_LO; fld_n = F_READ; bc_n = '0;
        tmr_load = 1'b1; tmr_val = span(T_LO);
      end
      S_GAP_END: if (tmr_zero) begin
        tmr_load = 1'b1;
        case (op_q)
          OP_PROG:      begin st_n = S_WAIT; tmr_val = span(W_PROG); end
          OP_ROWERASE:  begin st_n = S_WAIT; tmr_val = span(W_ROW);  end
          OP_BULKERASE: begin st_n = S_WAIT; tmr_val = span(W_BULK); end
          OP_READ:      st_n = S_RSP;
          default:      st_n = S_IDLE;
        endcase
      end
      S_WAIT: if (tmr_zero) st_n = S_IDLE;
      S_RSP:  if (rsp_ready) st_n = S_IDLE;
      S_TAIL: if (tmr_zero) begin st_n = S_IDLE; tr_n = 1'b0; end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; fld_q <= F_CMD; op_q <= '0; bc_q <= '0;
      clk_q <= 1'b0; oe_q <= 1'b1; tr_q <= 1'b0;
    end else begin
      st_q <= st_n; fld_q <= fld_n; op_q <= op_n; bc_q <= bc_n;
      clk_q <= clk_n; oe_q <= oe_n; tr_q <= tr_n;
    end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign busy       = (st_q != S_IDLE);
  assign rsp_valid  = (st_q == S_RSP);
  assign rsp_data   = sh_word;
  assign ser_clk    = clk_q;
  assign ser_dat_oe = oe_q;
  assign ser_dat_o  = oe_q & sh_lsb;
  assign tgt_reset  = tr_q;

  // High-phase length tracker for R4 checking
  logic [CNT_W-1:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len <= '0;
    else if (clk_q)  hi_len <= hi_len + 1'b1;
    else             hi_len <= '0;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk && $past(ser_clk) |-> $stable(ser_dat_o));
  a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> hi_len == CNT_W'(T_HI));
  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  a_r6_release_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dat_oe |-> busy);
  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_reset != $past(tgt_reset)) |-> !ser_clk && !$past(ser_clk));
endmodule

// File: tb/twsp_sequencer_tb.sv
module twsp_sequencer_tb_top;
  localparam int TL = 3, TH = 2, GC = 4, GR = 3, GE = 5;
  localparam int WP = 40, WR = 70, WB = 100, KL = 30, KT = 6;
  localparam logic [31:0] KEYV = 32'hA5C3_0F96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0, ser_dat_i = 1'b0;
  logic [2:0] req_op = '0;
  logic [3:0] req_cmd = '0;
  logic [15:0] req_data = '0;
  logic req_ready, rsp_valid, busy, ser_clk, ser_dat_o, ser_dat_oe, tgt_reset;
  logic [15:0] rsp_data;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  twsp_sequencer #(
    .CMD_W(4), .DATA_W(16), .KEY_W(32), .KEY_VALUE(KEYV), .CNT_W(32),
    .T_LO(TL), .T_HI(TH), .G_CMD(GC), .G_RD(GR), .G_END(GE),
    .W_PROG(WP), .W_ROW(WR), .W_BULK(WB), .KEY_LEAD(KL), .KEY_TAIL(KT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_cmd(req_cmd), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .ser_clk(ser_clk), .ser_dat_o(ser_dat_o), .ser_dat_oe(ser_dat_oe),
    .ser_dat_i(ser_dat_i), .tgt_reset(tgt_reset)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int n_rises(input logic [2:0] op);
    return (op == 3'd5) ? 32 : 20;
  endfunction

  function automatic int exp_busy(input logic [2:0] op, input int d);
    int b = TL + TH;
    case (op)
      3'd5: return KL + 32 * b + KT;
      3'd1: return 20 * b + GC + GR + GE + d + 1;
      3'd2: return 20 * b + GC + GE + WP;
      3'd3: return 20 * b + GC + GE + WR;
      3'd4: return 20 * b + GC + GE + WB;
      default: return 20 * b + GC + GE;
    endcase
  endfunction

  function automatic int exp_tail(input logic [2:0] op, input int d);
    case (op)
      3'd5: return KT;
      3'd1: return GE + d + 1;
      3'd2: return GE + WP;
      3'd3: return GE + WR;
      3'd4: return GE + WB;
      default: return GE;
    endcase
  endfunction

  function automatic int exp_low(input logic [2:0] op, input int i);
    if (op == 3'd5) return (i == 0) ? KL + TL : TL;
    if (i == 4) return (op == 3'd1) ? GC + GR + TL : GC + TL;
    return TL;
  endfunction

  function automatic logic [63:0] exp_bits(input logic [2:0] op, input logic [3:0] c,
                                           input logic [15:0] d);
    logic [63:0] v = '0;
    if (op == 3'd5) v[31:0] = KEYV;
    else if (op == 3'd1) v[3:0] = c;
    else v[19:0] = {d, c};
    return v;
  endfunction

  task automatic run_txn(input logic [2:0] op, input logic [3:0] c, input logic [15:0] d,
                         input logic [15:0] rword, input int dly);
    int bcnt = 0, nr = 0, lo_run = 0, hi_run = 0, hi_bad = 0, lo_bad = 0;
    int rdy_bad = 0, rd_idx = 0, vcnt = 0, stab_bad = 0;
    logic pclk = 1'b0, saw_rsp = 1'b0;
    logic [15:0] last_rsp = '0, got = '0;
    logic [63:0] cap = '0, oe_v = '0, rs_v = '0, oe_e = '0, rs_e = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_cmd = c; req_data = d;
    @(negedge clk);
    req_valid = 1'b0; req_cmd = ~c; req_data = ~d;
    chk("R2 busy after accept", busy, 1);
    while (busy === 1'b1 && bcnt < 100000) begin
      bcnt++;
      if (req_ready) rdy_bad++;
      if (!ser_dat_oe) begin
        if (rd_idx == 0) begin ser_dat_i = rword[0]; rd_idx = 1; end
        else if (pclk && !ser_clk && rd_idx < 16) begin
          ser_dat_i = rword[rd_idx]; rd_idx++;
        end
      end
      if (!pclk && ser_clk) begin
        if (nr < 64) begin
          cap[nr] = ser_dat_o; oe_v[nr] = ser_dat_oe; rs_v[nr] = tgt_reset;
          if (lo_run != exp_low(op, nr)) begin
            lo_bad++;
            $display("FAIL R4/R5/R6/R9 low before pulse %0d actual=%0d expected=%0d",
                     nr, lo_run, exp_low(op, nr));
          end
        end
        nr++; hi_run = 1;
      end else if (ser_clk) hi_run++;
      if (pclk && !ser_clk) begin
        if (hi_run != TH) hi_bad++;
        lo_run = 1;
      end else if (!ser_clk) lo_run++;
      if (rsp_valid) begin
        if (saw_rsp && rsp_data !== last_rsp) stab_bad++;
        last_rsp = rsp_data; got = rsp_data; saw_rsp = 1'b1;
        if (vcnt == dly) rsp_ready = 1'b1;
        vcnt++;
      end
      pclk = ser_clk;
      @(negedge clk);
    end
    rsp_ready = 1'b0;
    for (int i = 0; i < n_rises(op); i++) begin
      oe_e[i] = !(op == 3'd1 && i >= 4);
      rs_e[i] = (op == 3'd5);
    end
    chk("R2 busy length", bcnt, exp_busy(op, dly));
    chk("R2 ready low while busy", rdy_bad, 0);
    chk("R3/R9 pulse count", nr, n_rises(op));
    chk("R3/R9 serial bits", cap, exp_bits(op, c, d));
    chk("R4 high widths", hi_bad, 0);
    chk("R5 low intervals", lo_bad, 0);
    chk("R6 drive enable per pulse", oe_v, oe_e);
    chk("R9 reset level per pulse", rs_v, rs_e);
    chk("R7/R8/R9 trailing low", lo_run, exp_tail(op, dly));
    chk("R6 response only on read", saw_rsp, op == 3'd1);
    if (op == 3'd1) begin
      chk("R6 read word", got, rword);
      chk("R6 response stable", stab_bad, 0);
    end
    chk("R10 reset released at end", tgt_reset, 0);
    chk("R6 drive enable restored", ser_dat_oe, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ser_clk", ser_clk, 0);
    chk("R1 ser_dat_oe", ser_dat_oe, 1);
    chk("R1 tgt_reset", tgt_reset, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    run_txn(3'd5, 4'h9, 16'h1234, 16'h0, 0);     // R9 entry, fields ignored
    run_txn(3'd0, 4'hF, 16'hFFFF, 16'h0, 0);     // R3 all ones
    run_txn(3'd0, 4'h0, 16'h0000, 16'h0, 0);     // R3 all zeros
    run_txn(3'd1, 4'h8, 16'h0, 16'hA5A5, 7);     // R6 back-pressure
    run_txn(3'd1, 4'h1, 16'h0, 16'h8001, 0);     // R6 no wait
    run_txn(3'd2, 4'h3, 16'hBEEF, 16'h0, 0);     // R8 program
    run_txn(3'd3, 4'h5, 16'h0F0F, 16'h0, 0);     // R8 row erase
    run_txn(3'd4, 4'hA, 16'hF0F0, 16'h0, 0);     // R8 bulk erase
    run_txn(3'd6, 4'h6, 16'h1357, 16'h0, 0);     // R2 reserved code
    run_txn(3'd7, 4'hC, 16'h2468, 16'h0, 0);     // R2 reserved code
    for (int k = 0; k < 30; k++) begin
      run_txn(3'($urandom % 8), 4'($urandom), 16'($urandom), 16'($urandom),
              int'($urandom % 6));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule